// File: doc/BRIEF.md
# Audio Sample Requantizer with Mono Mix and Triangular Dither

This block sits behind a serial digital audio receiver. It takes one decoded left subframe and one decoded right subframe, each 32 bits, together with a strobe. From each subframe it cuts the 20-bit two's-complement audio word out of a fixed field. The auxiliary bits below that field are never merged into it. When mono is requested, both channels are replaced by their halved sum.

Each word is then reduced to the narrower output width, 16 bits by default. If dither is enabled, a zero-mean triangular-distribution offset is added before the low bits are dropped, and the result is clamped at the output's extreme codes.

A bypass flag arrives with each sample. It does not change the arithmetic; it travels beside the sample so that the downstream formatter knows which path the sample belongs to. Dither keeps working whether or not bypass is set. Processed samples leave with their own strobe a fixed two cycles after the input strobe.

Top module: `aud_out_stage`

## Requirements
- R1: The audio word of each channel is subframe bits 27 down to 8, read as a 20-bit two's-complement value with bit 27 as the sign. Subframe bits 31..28 and 7..0, including the auxiliary bits 7..4, have no effect on the outputs.
- R2: With mono and dither both off, each output equals its audio word divided by 16 and rounded toward minus infinity, which is an arithmetic shift right by 4.
- R3: With mono on, both channels use floor((left + right) / 2), formed at 21 bits so it cannot overflow. With dither off, out_l equals out_r.
- R4: out_valid is high exactly two cycles after each cycle with in_valid high and is low otherwise. Back-to-back inputs give back-to-back outputs. Between strobes, out_l, out_r and out_bypass hold their values.
- R5: Two 16-bit generators, A and B, start at 16'hACE1 and 16'h1D2B after reset. On every cycle with in_valid high, each does s <= {s[14:0], parity(s & T)}, with T_A = 16'hB400 and T_B = 16'hD008. They advance whether or not dither is on. A sample uses the generator states from before its own advance.
- R6: With dither on, the left word gets A[3:0] - B[3:0] added to it and the right word gets A[7:4] - B[7:4] added to it. Both fields are read as unsigned. The offset is added after any mono mix and before the floor division by 16.
- R7: A dithered result above 32767 comes out as 16'h7FFF, and one below -32768 comes out as 16'h8000. Results never wrap.
- R8: cfg_bypass has no effect on sample values or on dither. Its value at the input strobe appears on out_bypass alongside that sample.
- R9: While rst_n is low, out_valid, out_l, out_r and out_bypass are 0 and both generators return to their seeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Both subframes are present this cycle |
| in_sub_l | input | 32 | Left decoded subframe |
| in_sub_r | input | 32 | Right decoded subframe |
| cfg_mono | input | 1 | Replace both channels with their average |
| cfg_dither | input | 1 | Add triangular dither before requantizing |
| cfg_bypass | input | 1 | Path tag carried alongside the sample |
| out_valid | output | 1 | Processed sample strobe |
| out_l | output | 16 | Left output sample, two's complement |
| out_r | output | 16 | Right output sample, two's complement |
| out_bypass | output | 1 | Bypass tag of the sample on the outputs |

## Verification
Plain words are sent with random-looking bits in the subframe fields outside the audio word, so any leak of those bits shows up. Negative values check that rounding goes toward minus infinity and not toward zero. Mono pairs with opposite signs and odd sums separate a floor halving from a truncating halving and from a wrapped sum. Runs with dither on and off, including stretches where the generators advance while dither is off, pin down the generator step, its seeds and which bit fields feed which channel. Full-scale positive and negative words with dither force both clamps. Bursts with and without gaps, with bypass toggled, check the two-cycle latency, the holding of outputs between strobes and that the bypass tag travels with the sample.

// File: rtl/aud_out_pkg.sv
package aud_out_pkg;
  // channel ordering used for every per-channel array
  localparam int NCH = 2;
  typedef enum int {CH_L = 0, CH_R = 1} chan_e;

  localparam int DEF_SUB_W   = 32;
  localparam int DEF_AUD_LSB = 8;
  localparam int DEF_AUD_W   = 20;
  localparam int DEF_OUT_W   = 16;
  localparam int DEF_LFSR_W  = 16;
endpackage

// File: rtl/aud_lfsr.sv
module aud_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_nxt;

  always_comb begin
    state_nxt = state_q;
    if (adv) state_nxt = {state_q[W-2:0], ^(state_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_nxt;
  end

  assign state = state_q;

  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R5
  lfsr_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q));
endmodule

// File: rtl/aud_field_mix.sv
module aud_field_mix #(
  parameter int SUB_W   = 32,
  parameter int AUD_LSB = 8,
  parameter int AUD_W   = 20
) (
  input  logic [SUB_W-1:0] sub_l,
  input  logic [SUB_W-1:0] sub_r,
  input  logic             mono,
  output logic [AUD_W-1:0] word_l,
  output logic [AUD_W-1:0] word_r
);
  import aud_out_pkg::*;

  localparam int SUM_W = AUD_W + 1;

  logic [SUB_W-1:0] sub [NCH];
  logic [AUD_W-1:0] raw [NCH];
  logic [SUM_W-1:0] sum;
  logic [AUD_W-1:0] avg;

  assign sub[CH_L] = sub_l;
  assign sub[CH_R] = sub_r;

  for (genvar c = 0; c < NCH; c++) begin : g_field
    assign raw[c] = sub[c][AUD_LSB +: AUD_W];
  end

  always_comb begin
    sum = {raw[CH_L][AUD_W-1], raw[CH_L]} + {raw[CH_R][AUD_W-1], raw[CH_R]};
    avg = sum[SUM_W-1:1];
  end

  assign word_l = mono ? avg : raw[CH_L];
  assign word_r = mono ? avg : raw[CH_R];
endmodule

// File: rtl/aud_requant.sv
module aud_requant #(
  parameter int AUD_W = 20,
  parameter int OUT_W = 16
) (
  input  logic [AUD_W-1:0]         word,
  input  logic                     dith_en,
  input  logic [AUD_W-OUT_W-1:0]   ua,
  input  logic [AUD_W-OUT_W-1:0]   ub,
  output logic [OUT_W-1:0]         q
);
  localparam int DW = AUD_W - OUT_W;
  localparam int VW = AUD_W + 2;
  localparam logic signed [VW-1:0] HI = VW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [VW-1:0] LO = -HI - VW'(1);

  logic signed [DW+1:0] diff;
  logic signed [VW-1:0] wide;
  logic signed [VW-1:0] sh;

  always_comb begin
    diff = dith_en ? ($signed({2'b00, ua}) - $signed({2'b00, ub})) : '0;
    wide = $signed({{2{word[AUD_W-1]}}, word}) + $signed({{(VW-DW-2){diff[DW+1]}}, diff});
    sh   = wide >>> DW;
    if (sh > HI)      q = HI[OUT_W-1:0];
    else if (sh < LO) q = LO[OUT_W-1:0];
    else              q = sh[OUT_W-1:0];
  end
endmodule

// File: rtl/aud_out_stage.sv
module aud_out_stage
  import aud_out_pkg::*;
#(
  parameter int                 SUB_W   = DEF_SUB_W,
  parameter int                 AUD_LSB = DEF_AUD_LSB,
  parameter int                 AUD_W   = DEF_AUD_W,
  parameter int                 OUT_W   = DEF_OUT_W,
  parameter int                 LFSR_W  = DEF_LFSR_W,
  parameter logic [LFSR_W-1:0]  TAPS_A  = 16'hB400,
  parameter logic [LFSR_W-1:0]  SEED_A  = 16'hACE1,
  parameter logic [LFSR_W-1:0]  TAPS_B  = 16'hD008,
  parameter logic [LFSR_W-1:0]  SEED_B  = 16'h1D2B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SUB_W-1:0] in_sub_l,
  input  logic [SUB_W-1:0] in_sub_r,
  input  logic             cfg_mono,
  input  logic             cfg_dither,
  input  logic             cfg_bypass,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_l,
  output logic [OUT_W-1:0] out_r,
  output logic             out_bypass
);
  localparam int DW = AUD_W - OUT_W;

  // dither generators
  logic [LFSR_W-1:0] gen_a;
  logic [LFSR_W-1:0] gen_b;

  aud_lfsr #(.W(LFSR_W), .TAPS(TAPS_A), .SEED(SEED_A)) u_gen_a (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .state(gen_a));
  aud_lfsr #(.W(LFSR_W), .TAPS(TAPS_B), .SEED(SEED_B)) u_gen_b (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .state(gen_b));

  // field extraction and mono mix
  logic [AUD_W-1:0] mix_w [NCH];

  aud_field_mix #(.SUB_W(SUB_W), .AUD_LSB(AUD_LSB), .AUD_W(AUD_W)) u_mix (
    .sub_l(in_sub_l), .sub_r(in_sub_r), .mono(cfg_mono),
    .word_l(mix_w[CH_L]), .word_r(mix_w[CH_R]));

  // stage 1 registers
  logic             s1_vld,  s1_vld_nxt;
  logic             s1_dith, s1_dith_nxt;
  logic             s1_byp,  s1_byp_nxt;
  logic [AUD_W-1:0] s1_word [NCH];
  logic [AUD_W-1:0] s1_word_nxt [NCH];
  logic [DW-1:0]    s1_ua [NCH];
  logic [DW-1:0]    s1_ua_nxt [NCH];
  logic [DW-1:0]    s1_ub [NCH];
  logic [DW-1:0]    s1_ub_nxt [NCH];

  always_comb begin
    s1_vld_nxt  = in_valid;
    s1_dith_nxt = s1_dith;
    s1_byp_nxt  = s1_byp;
    for (int c = 0; c < NCH; c++) begin
      s1_word_nxt[c] = s1_word[c];
      s1_ua_nxt[c]   = s1_ua[c];
      s1_ub_nxt[c]   = s1_ub[c];
    end
    if (in_valid) begin
      s1_dith_nxt = cfg_dither;
      s1_byp_nxt  = cfg_bypass;
      for (int c = 0; c < NCH; c++) begin
        s1_word_nxt[c] = mix_w[c];
        s1_ua_nxt[c]   = gen_a[c*DW +: DW];
        s1_ub_nxt[c]   = gen_b[c*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_dith <= 1'b0;
      s1_byp  <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        s1_word[c] <= '0;
        s1_ua[c]   <= '0;
        s1_ub[c]   <= '0;
      end
    end else begin
      s1_vld  <= s1_vld_nxt;
      s1_dith <= s1_dith_nxt;
      s1_byp  <= s1_byp_nxt;
      for (int c = 0; c < NCH; c++) begin
        s1_word[c] <= s1_word_nxt[c];
        s1_ua[c]   <= s1_ua_nxt[c];
        s1_ub[c]   <= s1_ub_nxt[c];
      end
    end
  end

  // requantization per channel
  logic [OUT_W-1:0] rq [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_rq
    aud_requant #(.AUD_W(AUD_W), .OUT_W(OUT_W)) u_rq (
      .word(s1_word[c]), .dith_en(s1_dith),
      .ua(s1_ua[c]), .ub(s1_ub[c]), .q(rq[c]));
  end

  // stage 2 registers
  logic             o_vld, o_vld_nxt;
  logic             o_byp, o_byp_nxt;
  logic [OUT_W-1:0] o_q [NCH];
  logic [OUT_W-1:0] o_q_nxt [NCH];

  always_comb begin
    o_vld_nxt = s1_vld;
    o_byp_nxt = o_byp;
    for (int c = 0; c < NCH; c++) o_q_nxt[c] = o_q[c];
    if (s1_vld) begin
      o_byp_nxt = s1_byp;
      for (int c = 0; c < NCH; c++) o_q_nxt[c] = rq[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld <= 1'b0;
      o_byp <= 1'b0;
      for (int c = 0; c < NCH; c++) o_q[c] <= '0;
    end else begin
      o_vld <= o_vld_nxt;
      o_byp <= o_byp_nxt;
      for (int c = 0; c < NCH; c++) o_q[c] <= o_q_nxt[c];
    end
  end

  assign out_valid  = o_vld;
  assign out_bypass = o_byp;
  assign out_l      = o_q[CH_L];
  assign out_r      = o_q[CH_R];

  // R4
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R4
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  // R4
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_l) && $stable(out_r) && $stable(out_bypass)));

  // R3
  mono_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_mono && !cfg_dither) |-> ##2 (out_l == out_r));

  // R8
  bypass_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 (out_bypass == $past(cfg_bypass, 2)));
endmodule

// File: tb/tb_aud_out_stage.sv
module tb_aud_out_stage;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_sub_l, in_sub_r;
  logic        cfg_mono, cfg_dither, cfg_bypass;
  logic        out_valid;
  logic [15:0] out_l, out_r;
  logic        out_bypass;

  aud_out_stage dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_sub_l(in_sub_l), .in_sub_r(in_sub_r),
    .cfg_mono(cfg_mono), .cfg_dither(cfg_dither), .cfg_bypass(cfg_bypass),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r), .out_bypass(out_bypass));

  always #4 clk = ~clk;

  typedef struct {
    int    due;
    int    l;
    int    r;
    bit    byp;
    string tag;
  } exp_t;

  exp_t        expq[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          chk_on = 0;
  bit          done = 0;
  int          last_l = 0, last_r = 0;
  bit          last_b = 0;
  logic [15:0] ma, mb;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] gen_step(input logic [15:0] s, input logic [15:0] t);
    return {s[14:0], ^(s & t)};
  endfunction

  function automatic int clamp16(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // reference model: one entry per accepted sample
  task automatic send(input logic [19:0] l, input logic [19:0] r,
                      input bit mono, input bit dith, input bit byp,
                      input logic [11:0] junk, input string tag);
    int li, ri, dl, dr;
    exp_t e;
    @(negedge clk);
    in_valid   = 1'b1;
    in_sub_l   = {junk[11:8], l, junk[7:0]};
    in_sub_r   = {~junk[11:8], r, ~junk[7:0]};
    cfg_mono   = mono;
    cfg_dither = dith;
    cfg_bypass = byp;
    li = int'($signed(l));
    ri = int'($signed(r));
    if (mono) begin
      li = (li + ri) >>> 1;
      ri = li;
    end
    dl = dith ? (int'(ma[3:0]) - int'(mb[3:0])) : 0;
    dr = dith ? (int'(ma[7:4]) - int'(mb[7:4])) : 0;
    e.due = cyc + 2;
    e.l   = clamp16((li + dl) >>> 4);
    e.r   = clamp16((ri + dr) >>> 4);
    e.byp = byp;
    e.tag = tag;
    expq.push_back(e);
    ma = gen_step(ma, 16'hB400);
    mb = gen_step(mb, 16'hD008);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid   = 1'b0;
      in_sub_l   = 32'hDEAD_BEEF ^ 32'(i);
      in_sub_r   = 32'h1234_5678 + 32'(i);
      cfg_mono   = i[0];
      cfg_dither = i[1];
      cfg_bypass = ~i[0];
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      if (expq.size() > 0 && expq[0].due == cyc) begin
        chk(out_valid == 1'b1, "R4", "out_valid at due", int'(out_valid), 1);
        chk(int'($signed(out_l)) == expq[0].l, expq[0].tag, "out_l", int'($signed(out_l)), expq[0].l);
        chk(int'($signed(out_r)) == expq[0].r, expq[0].tag, "out_r", int'($signed(out_r)), expq[0].r);
        chk(out_bypass == expq[0].byp, "R8", "out_bypass", int'(out_bypass), int'(expq[0].byp));
        last_l = expq[0].l;
        last_r = expq[0].r;
        last_b = expq[0].byp;
        void'(expq.pop_front());
      end else begin
        chk(out_valid == 1'b0, "R4", "out_valid idle", int'(out_valid), 0);
        chk(int'($signed(out_l)) == last_l && int'($signed(out_r)) == last_r && out_bypass == last_b,
            "R4", "hold left", int'($signed(out_l)), last_l);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sub_l = '0; in_sub_r = '0;
    cfg_mono = 0; cfg_dither = 0; cfg_bypass = 0;
    ma = 16'hACE1;
    mb = 16'h1D2B;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(out_valid == 0, "R9", "out_valid in reset", int'(out_valid), 0);
    chk(out_l == 0 && out_r == 0, "R9", "out_l/out_r in reset", int'(out_l), 0);
    chk(out_bypass == 0, "R9", "out_bypass in reset", int'(out_bypass), 0);
    @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1;

    // R5 R9: first dithered samples use the seeds
    send(20'h00100, 20'hFFF00, 0, 1, 0, 12'hA5C, "R5");
    send(20'h12345, 20'h80010, 0, 1, 0, 12'h3F0, "R6");
    idle(3);

    // R1 R2: plain words, junk outside the field, negative floors
    send(20'h00010, 20'hFFFF1, 0, 0, 0, 12'hFFF, "R1");
    send(20'h7FFFF, 20'h80000, 0, 0, 0, 12'h000, "R2");
    send(20'hFFFFF, 20'h0000F, 0, 0, 0, 12'h5A5, "R2");
    send(20'h3C3C3, 20'hC3C3C, 0, 0, 0, 12'h9F3, "R1");
    idle(2);

    // R3: mono with odd and opposite-sign sums
    send(20'h00005, 20'hFFFF8, 1, 0, 0, 12'h111, "R3");
    send(20'h7FFFF, 20'h7FFFF, 1, 0, 1, 12'h222, "R3");
    send(20'h80000, 20'h80000, 1, 0, 0, 12'h333, "R3");
    send(20'h80000, 20'h7FFFF, 1, 0, 0, 12'h444, "R3");
    send(20'h00021, 20'h00010, 1, 1, 0, 12'h555, "R3");
    idle(4);

    // R5: generators keep advancing with dither off
    for (int i = 0; i < 7; i++)
      send(20'(i * 4099), 20'(i * 777), 0, 0, 0, 12'(i), "R5");
    send(20'h00400, 20'hFFC00, 0, 1, 0, 12'hABC, "R5");
    idle(2);

    // R6: dither over a spread of words
    for (int i = 0; i < 24; i++)
      send(20'(i * 43691), 20'(20'hFFFFF - i * 9973), i[2], 1, 0, 12'(i * 37), "R6");
    idle(3);

    // R7: full-scale with dither drives both clamps
    for (int i = 0; i < 20; i++)
      send(20'h7FFFF, 20'h80000, 0, 1, 0, 12'(i * 101), "R7");
    for (int i = 0; i < 10; i++)
      send(20'h80000, 20'h7FFFF, 0, 1, 0, 12'(i * 53), "R7");
    idle(3);

    // R8: bypass toggled, dither unaffected
    for (int i = 0; i < 12; i++)
      send(20'(20'h12000 + i * 333), 20'(20'hE1000 - i * 211), 0, 1, i[0], 12'(i), "R8");
    idle(2);

    // R4: gapped bursts
    for (int i = 0; i < 6; i++) begin
      send(20'(i * 5000), 20'(i * 7000), 0, i[0], i[1], 12'(i), "R4");
      idle(i % 3);
    end
    idle(5);

    chk(expq.size() == 0, "R4", "samples left unseen", expq.size(), 0);
    finish_run();
  end
endmodule